// File: doc/BRIEF.md
# Bus-Master DMA Line Buffer

A single line buffer sits between a storage device's data path and host memory. It works in one of two modes at a time. In write mode (device to memory) it gathers DWords from the device into a line of four and hands the whole line to memory as one burst. In read mode (memory to device) it takes DWords from memory one at a time and passes them to the device in order. The mode can change only when the buffer holds nothing.

A burst that is cut short, by an explicit flush at the end of a transfer or by a completion or interrupt event, still goes out as a four-DWord burst. Each unused DWord carries an active-low byte-enable nibble of 0xF. When a descriptor-completion event or a device interrupt arrives while write data is still in the buffer, the block raises a retry flag. The host-side target logic uses this flag to answer non-memory reads with retry, so software cannot read status before the data it describes has reached memory.

Top module: `lb_line_buffer`

## Requirements
- R1: After reset the buffer is empty and in read mode: curModeWrite, memBurstValid, devRdValid and hostRetry are all 0.
- R2: The mode register follows modeWriteReq only in a cycle where the buffer is empty. In that switching cycle devWrReady and memFillReady are 0. While the buffer holds data the mode does not change.
- R3: In write mode, four accepted device DWords form one burst. Word i sits at memBurstData[32i+31:32i], and memBurstBeN is 16'h0000. The burst stays valid with stable data until memBurstReady is high.
- R4: While a burst is waiting for memory, devWrReady is 0.
- R5: A flushReq pulse in write mode with n (1..3) DWords buffered sends a burst. The nibble memBurstBeN[4i+3:4i] is 0x0 for i<n and 0xF for the other words.
- R6: An eotEvent or irqEvent pulse in write mode with data buffered raises hostRetry on the next clock and flushes the partial line as in R5.
- R7: hostRetry drops on the clock edge at which memory accepts the burst. An event with an empty buffer does not raise it.
- R8: In read mode the buffer takes up to four DWords from memory, memFillReady is 0 when it is full, and the device receives the words in arrival order.
- R9: In read mode memBurstValid and devWrReady stay 0, and events do not raise hostRetry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWriteReq | input | 1 | Requested mode, 1 = device to memory |
| curModeWrite | output | 1 | Current mode |
| devWrValid | input | 1 | Device offers a DWord (write mode) |
| devWrData | input | 32 | Device DWord |
| devWrReady | output | 1 | Buffer takes the device DWord |
| devRdValid | output | 1 | Buffer offers a DWord to the device (read mode) |
| devRdData | output | 32 | DWord to the device |
| devRdReady | input | 1 | Device takes the DWord |
| memFillValid | input | 1 | Memory offers a DWord (read mode) |
| memFillData | input | 32 | Memory DWord |
| memFillReady | output | 1 | Buffer takes the memory DWord |
| memBurstValid | output | 1 | Write burst pending |
| memBurstData | output | 128 | Burst line, word 0 in the low bits |
| memBurstBeN | output | 16 | Active-low byte enables, 4 per word |
| memBurstReady | input | 1 | Memory accepts the burst |
| flushReq | input | 1 | End-of-transfer flush pulse |
| eotEvent | input | 1 | Descriptor-completion pulse |
| irqEvent | input | 1 | Device interrupt pulse |
| hostRetry | output | 1 | Retry host non-memory reads |

## Verification
On every cycle the assertions check that a mode change happens only after an empty cycle, that device writes stall while a burst waits, that a waiting burst holds steady, that retry is gone after an acceptance, and that read mode never produces bursts, write readiness or retry. Only the bench scenarios can show the exact burst contents and byte-enable patterns for full and partial lines, the one-clock delay of retry after an event, the refusal to change mode while data is held, and the order of the read data.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic lineClr;
    logic selDev;
  } lbStrobe_t;
endpackage

// File: rtl/lb_datapath.sv
module lb_datapath
  import lb_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter int DATA_W = 32,
  localparam int PTR_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int CNT_W = $clog2(LINE_WORDS + 1),
  localparam int BE_W = DATA_W / 8
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  lbStrobe_t                    stb,
  input  logic [DATA_W-1:0]            devData,
  input  logic [DATA_W-1:0]            fillData,
  output logic [CNT_W-1:0]             cnt,
  output logic [DATA_W-1:0]            rdData,
  output logic [LINE_WORDS*DATA_W-1:0] lineData,
  output logic [LINE_WORDS*BE_W-1:0]   lineBeN
);
  logic [DATA_W-1:0] store [LINE_WORDS];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(LINE_WORDS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.wrEn) store[wrPtr] <= stb.selDev ? devData : fillData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.lineClr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (stb.wrEn) wrPtr <= bump(wrPtr);
      if (stb.rdEn) rdPtr <= bump(rdPtr);
      cnt <= cnt + CNT_W'(stb.wrEn) - CNT_W'(stb.rdEn);
    end
  end

  assign rdData = store[rdPtr];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    logic used;
    assign used = CNT_W'(w) < cnt;
    assign lineData[w*DATA_W +: DATA_W] = used ? store[w] : '0;
    assign lineBeN[w*BE_W +: BE_W]      = used ? '0 : '1;
  end
endmodule

// File: rtl/lb_control.sv
module lb_control
  import lb_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int CNT_W = $clog2(LINE_WORDS + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWriteReq,
  input  logic [CNT_W-1:0] cnt,
  input  logic             devWrValid,
  input  logic             devRdReady,
  input  logic             memFillValid,
  input  logic             memBurstReady,
  input  logic             flushReq,
  input  logic             eotEvent,
  input  logic             irqEvent,
  output lbStrobe_t        stb,
  output logic             curModeWrite,
  output logic             devWrReady,
  output logic             devRdValid,
  output logic             memFillReady,
  output logic             memBurstValid,
  output logic             hostRetry
);
  logic modeW, flushPend, retryPend;
  logic isEmpty, isFull, switching, push, pop, fill, burstAcc, evt, nonEmptyNext;

  assign isEmpty   = (cnt == '0);
  assign isFull    = (cnt == CNT_W'(LINE_WORDS));
  assign switching = isEmpty && (modeWriteReq != modeW);
  assign evt       = eotEvent || irqEvent;

  assign memBurstValid = modeW && (isFull || (flushPend && !isEmpty));
  assign devWrReady    = modeW && !memBurstValid && !switching;
  assign memFillReady  = !modeW && !isFull && !switching;
  assign devRdValid    = !modeW && !isEmpty;

  assign push     = devWrValid && devWrReady;
  assign fill     = memFillValid && memFillReady;
  assign pop      = devRdValid && devRdReady;
  assign burstAcc = memBurstValid && memBurstReady;
  assign nonEmptyNext = !burstAcc && (!isEmpty || push);

  always_comb begin
    stb.wrEn    = push || fill;
    stb.rdEn    = pop;
    stb.lineClr = burstAcc || switching;
    stb.selDev  = modeW;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeW     <= 1'b0;
      flushPend <= 1'b0;
      retryPend <= 1'b0;
    end else begin
      if (switching) modeW <= modeWriteReq;
      if (modeW && (flushReq || evt)) flushPend <= 1'b1;
      else if (burstAcc || isEmpty)   flushPend <= 1'b0;
      retryPend <= modeW && nonEmptyNext && (evt || retryPend);
    end
  end

  assign curModeWrite = modeW;
  assign hostRetry    = retryPend;
endmodule

// File: rtl/lb_line_buffer.sv
module lb_line_buffer
  import lb_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(LINE_WORDS + 1),
  localparam int BE_W = DATA_W / 8
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         modeWriteReq,
  output logic                         curModeWrite,
  input  logic                         devWrValid,
  input  logic [DATA_W-1:0]            devWrData,
  output logic                         devWrReady,
  output logic                         devRdValid,
  output logic [DATA_W-1:0]            devRdData,
  input  logic                         devRdReady,
  input  logic                         memFillValid,
  input  logic [DATA_W-1:0]            memFillData,
  output logic                         memFillReady,
  output logic                         memBurstValid,
  output logic [LINE_WORDS*DATA_W-1:0] memBurstData,
  output logic [LINE_WORDS*BE_W-1:0]   memBurstBeN,
  input  logic                         memBurstReady,
  input  logic                         flushReq,
  input  logic                         eotEvent,
  input  logic                         irqEvent,
  output logic                         hostRetry
);
  lbStrobe_t        stb;
  logic [CNT_W-1:0] fillCount;

  lb_control #(.LINE_WORDS(LINE_WORDS)) u_ctl (
    .clk(clk), .rstN(rstN), .modeWriteReq(modeWriteReq), .cnt(fillCount),
    .devWrValid(devWrValid), .devRdReady(devRdReady), .memFillValid(memFillValid),
    .memBurstReady(memBurstReady), .flushReq(flushReq), .eotEvent(eotEvent),
    .irqEvent(irqEvent), .stb(stb), .curModeWrite(curModeWrite),
    .devWrReady(devWrReady), .devRdValid(devRdValid), .memFillReady(memFillReady),
    .memBurstValid(memBurstValid), .hostRetry(hostRetry)
  );

  lb_datapath #(.LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .devData(devWrData), .fillData(memFillData),
    .cnt(fillCount), .rdData(devRdData), .lineData(memBurstData), .lineBeN(memBurstBeN)
  );
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int LINE_WORDS = 4,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(LINE_WORDS + 1)
)(
  input logic                         clk,
  input logic                         rstN,
  input logic [CNT_W-1:0]             fillCount,
  input logic                         curModeWrite,
  input logic                         devWrReady,
  input logic                         memFillReady,
  input logic                         memBurstValid,
  input logic                         memBurstReady,
  input logic [LINE_WORDS*DATA_W-1:0] memBurstData,
  input logic                         hostRetry
);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curModeWrite) |-> ($past(fillCount) == '0));
  // R4
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    memBurstValid |-> !devWrReady);
  // R3
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memBurstValid && !memBurstReady) |=> (memBurstValid && $stable(memBurstData)));
  // R7
  retry_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memBurstValid && memBurstReady) |=> !hostRetry);
  // R8
  fill_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == CNT_W'(LINE_WORDS)) |-> !memFillReady);
  // R9
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !curModeWrite |-> (!memBurstValid && !devWrReady && !hostRetry));
endmodule

bind lb_line_buffer lb_checker #(.LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .fillCount(fillCount), .curModeWrite(curModeWrite),
  .devWrReady(devWrReady), .memFillReady(memFillReady), .memBurstValid(memBurstValid),
  .memBurstReady(memBurstReady), .memBurstData(memBurstData), .hostRetry(hostRetry)
);

// File: tb/tb_lb_line_buffer.sv
module tb_lb_line_buffer;
  logic clk = 1'b0, rstN = 1'b0;
  logic modeWriteReq = 0, devWrValid = 0, devRdReady = 0, memFillValid = 0;
  logic memBurstReady = 0, flushReq = 0, eotEvent = 0, irqEvent = 0;
  logic [31:0] devWrData = '0, memFillData = '0, devRdData;
  logic curModeWrite, devWrReady, devRdValid, memFillReady, memBurstValid, hostRetry;
  logic [127:0] memBurstData;
  logic [15:0]  memBurstBeN;
  int total = 0, bad = 0;
  bit finished = 0;

  localparam logic [127:0] LINES [3] = '{
    128'h44444444_33333333_22222222_11111111,
    128'hDEADBEEF_0BADF00D_CAFEF00D_12345678,
    128'h00000000_FFFFFFFF_A5A5A5A5_5A5A5A5A
  };

  always #2.5 clk = ~clk;

  lb_line_buffer dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pushWord(input logic [31:0] d);
    devWrValid = 1; devWrData = d;
    #1;
    while (!devWrReady) begin @(negedge clk); #1; end
    @(negedge clk); devWrValid = 0;
  endtask

  task automatic fillWord(input logic [31:0] d);
    memFillValid = 1; memFillData = d;
    #1;
    while (!memFillReady) begin @(negedge clk); #1; end
    @(negedge clk); memFillValid = 0;
  endtask

  task automatic acceptBurst();
    memBurstReady = 1;
    @(negedge clk); memBurstReady = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk("R1 reset", {curModeWrite, memBurstValid, devRdValid, hostRetry}, 4'b0000);

    // R2 switch to write mode: readies blocked in the switching cycle
    @(negedge clk); modeWriteReq = 1; #1;
    chk("R2 switch cycle", {devWrReady, memFillReady}, 2'b00);
    @(negedge clk); #1;
    chk("R2 now write", {curModeWrite, devWrReady}, 2'b11);

    // R3 R4 full-line bursts from the table
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 4; i++) pushWord(LINES[k][32*i +: 32]);
      #1;
      chk("R3 burst data", memBurstData, LINES[k]);
      chk("R3 burst be", {memBurstValid, memBurstBeN}, {1'b1, 16'h0000});
      chk("R4 stall", devWrReady, 1'b0);
      @(negedge clk); #1;
      chk("R3 burst held", {memBurstValid, memBurstData}, {1'b1, LINES[k]});
      acceptBurst(); #1;
      chk("R3 burst gone", memBurstValid, 1'b0);
    end

    // R5 partial flush of three words
    for (int i = 0; i < 3; i++) pushWord(32'hB000_0000 + i);
    #1; chk("R5 no burst before flush", memBurstValid, 1'b0);
    flushReq = 1; @(negedge clk); flushReq = 0; #1;
    chk("R5 partial be", {memBurstValid, memBurstBeN}, {1'b1, 16'hF000});
    chk("R5 partial data", memBurstData, {32'h0, 32'hB000_0002, 32'hB000_0001, 32'hB000_0000});
    chk("R5 no retry on flush", hostRetry, 1'b0);
    acceptBurst();

    // R6 R7 interrupt with two words pending
    pushWord(32'hC0C0_0001); pushWord(32'hC0C0_0002);
    #1; chk("R6 before event", hostRetry, 1'b0);
    irqEvent = 1; @(negedge clk); irqEvent = 0; #1;
    chk("R6 retry raised", hostRetry, 1'b1);
    chk("R6 flush be", {memBurstValid, memBurstBeN}, {1'b1, 16'hFF00});
    @(negedge clk); #1;
    chk("R7 retry held while pending", hostRetry, 1'b1);
    acceptBurst(); #1;
    chk("R7 retry dropped", hostRetry, 1'b0);

    // R6 completion event with one word
    pushWord(32'hE0E0_0001);
    eotEvent = 1; @(negedge clk); eotEvent = 0; #1;
    chk("R6 eot retry", {hostRetry, memBurstBeN}, {1'b1, 16'hFFF0});
    acceptBurst(); #1;
    chk("R7 eot retry dropped", hostRetry, 1'b0);

    // R7 event with empty buffer
    eotEvent = 1; @(negedge clk); eotEvent = 0; #1;
    chk("R7 empty event", {hostRetry, memBurstValid}, 2'b00);

    // R2 mode change refused while data held
    pushWord(32'h7777_0001);
    modeWriteReq = 0;
    repeat (2) @(negedge clk); #1;
    chk("R2 mode held", curModeWrite, 1'b1);
    flushReq = 1; @(negedge clk); flushReq = 0;
    acceptBurst();
    @(negedge clk); #1;
    chk("R2 now read", curModeWrite, 1'b0);

    // R8 read mode fill and drain
    for (int i = 0; i < 4; i++) fillWord(32'hD000_0000 + i);
    #1;
    chk("R8 full", {memFillReady, devRdValid}, 2'b01);
    // R9 events and device writes ignored in read mode
    devWrValid = 1; irqEvent = 1; eotEvent = 1;
    #0.5;
    chk("R9 write ignored", devWrReady, 1'b0);
    @(negedge clk); irqEvent = 0; eotEvent = 0; devWrValid = 0; #1;
    chk("R9 quiet", {hostRetry, memBurstValid}, 2'b00);
    devRdReady = 1;
    for (int i = 0; i < 4; i++) begin
      chk("R8 read order", {devRdValid, devRdData}, {1'b1, 32'hD000_0000 + i});
      @(negedge clk); #1;
    end
    devRdReady = 0;
    chk("R8 drained", {devRdValid, memFillReady}, 2'b01);

    finish();
  end
endmodule